// File: doc/BRIEF.md
# Prescaled Timer Base Unit

A 16-bit time base for a timer block, programmed through a small word-addressed register file. A programmable divider turns the clock into count ticks, and on each tick the counter steps in one of three shapes: a rising sawtooth, a falling sawtooth, or a triangle (0 up to the period value and back to 0). Every wrap or turn-around is an update event. An update event sets a sticky status flag, can raise an interrupt, reloads the buffered divider value and can transfer a buffered period value. A single-shot mode stops the counter at its first update event.

Software writes the divider, the period and the interrupt enable, issues a software update through the event register so that the counter and the buffered values start from a known point, and then sets the enable bit. The counter value, the effective counting direction and a one-cycle update pulse go to a compare-channel bank. In triangle mode that bank uses the direction output to raise its compare flags only on the falling half.

Top module: `tmr_base_unit`

## Requirements
- R1: The divider register (offset 2) holding value P makes the counter step once every P+1 clocks while enabled. A new divider value is used only from the next update event.
- R2: With control bits [3:2]=0 and bit 1=0, the counter counts up to the active period value. On the tick after it reaches that value it goes to 0, which is an update event.
- R3: With control bits [3:2]=0 and bit 1=1, the counter counts down. On the tick after it reaches 0 it loads the period register (offset 3), which is an update event.
- R4: With control bits [3:2] nonzero, the counter runs 0→period→0, with an update event at each turn-around. dir_down_o is 1 on the falling half. Writes to control bit 1 are ignored in this mode, and a read of control bit 1 returns the current phase.
- R5: With control bit 4 set, the first counter-driven update event clears the enable bit (control bit 0) and the counter holds its wrapped value.
- R6: With control bit 5 set, a period write takes effect only at the next update event. With bit 5 clear it takes effect at once.
- R7: Writing 1 to bit 0 of the event register (offset 1) is an update event. It clears the divider phase, loads the counter with 0 (or with the period register when counting down in sawtooth mode), starts the triangle on its rising half and transfers both buffered values.
- R8: Status bit 0 (offset 5) is set by every update event. Writing 0 to it clears it, writing 1 has no effect, and a set in the same cycle wins over the clear.
- R9: irq_o is status bit 0 ANDed with interrupt-enable bit 0 (offset 4).
- R10: upd_o is high for one cycle after each update event, in the same cycle as the counter value that the event produced.
- R11: After reset the counter, all registers and all outputs are 0. The counter value reads back at offset 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| cnt_o | output | 16 | Counter value |
| dir_down_o | output | 1 | Effective direction, 1 = counting down |
| upd_o | output | 1 | Update event pulse |
| irq_o | output | 1 | Update interrupt |

## Verification
A wrong divider phase or a buffered value that is transferred at the wrong time shows up as a count step that comes one tick early or late, or as a wrap at the wrong value. This is visible on cnt_o within one period. A wrong triangle phase flips dir_down_o and the count direction at the next tick. A missed or spurious update event shows on upd_o in the next cycle and stays visible in the status bit and irq_o until software clears it. The bench runs a cycle-level model of the requirements next to the design and compares all four outputs on every cycle, both under random configurations and under directed cases for buffering, single-shot and flag handling.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_EVT  = 3'd1,
    A_PSC  = 3'd2,
    A_ARR  = 3'd3,
    A_IEN  = 3'd4,
    A_STAT = 3'd5,
    A_CNT  = 3'd6
  } reg_addr_e;

  localparam int unsigned CTRL_W = 6;

  // control word, LSB first: en, dir, cms[1:0], opm, arpe
  typedef struct packed {
    logic       arpe;
    logic       opm;
    logic [1:0] cms;
    logic       dir;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          upd_i,
  input  logic [CW-1:0] psc_pre_i,
  output logic          tick_o
);
  logic [CW-1:0] pcnt_q, psc_act_q;

  assign tick_o = en_i && (pcnt_q == psc_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q    <= '0;
      psc_act_q <= '0;
    end else if (upd_i) begin
      pcnt_q    <= '0;
      psc_act_q <= psc_pre_i;
    end else if (tick_o) begin
      pcnt_q    <= '0;
    end else if (en_i) begin
      pcnt_q    <= pcnt_q + 1'b1;
    end
  end

  AST_PSC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= psc_act_q); // R1
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          ug_i,
  input  logic          center_i,
  input  logic          dir_i,
  input  logic [CW-1:0] arr_pre_i,
  input  logic          arr_direct_i,
  input  logic [CW-1:0] arr_wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          dir_c_o,
  output logic          evt_o,
  output logic          hw_upd_o
);
  logic [CW-1:0] cnt_q, nxt_cnt, arr_act_q;
  logic          dirc_q, nxt_dirc, wrap;

  always_comb begin
    nxt_cnt  = cnt_q;
    nxt_dirc = dirc_q;
    wrap     = 1'b0;
    if (ug_i) begin
      nxt_cnt  = (!center_i && dir_i) ? arr_pre_i : '0;
      nxt_dirc = 1'b0;
    end else if (tick_i) begin
      if (center_i) begin
        if (arr_act_q == '0) begin
          nxt_cnt = '0;
          wrap    = 1'b1;
        end else if (!dirc_q) begin
          if (cnt_q >= arr_act_q) begin
            nxt_cnt  = arr_act_q - 1'b1;
            nxt_dirc = 1'b1;
            wrap     = 1'b1;
          end else begin
            nxt_cnt = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            nxt_cnt  = CW'(1);
            nxt_dirc = 1'b0;
            wrap     = 1'b1;
          end else begin
            nxt_cnt = cnt_q - 1'b1;
          end
        end
      end else if (dir_i) begin
        if (cnt_q == '0) begin
          nxt_cnt = arr_pre_i;
          wrap    = 1'b1;
        end else begin
          nxt_cnt = cnt_q - 1'b1;
        end
      end else begin
        if (cnt_q >= arr_act_q) begin
          nxt_cnt = '0;
          wrap    = 1'b1;
        end else begin
          nxt_cnt = cnt_q + 1'b1;
        end
      end
    end
  end

  assign hw_upd_o = wrap;
  assign evt_o    = ug_i | wrap;
  assign cnt_o    = cnt_q;
  assign dir_c_o  = dirc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      dirc_q    <= 1'b0;
      arr_act_q <= '0;
    end else begin
      cnt_q  <= nxt_cnt;
      dirc_q <= nxt_dirc;
      if (arr_direct_i)  arr_act_q <= arr_wdata_i;
      else if (evt_o)    arr_act_q <= arr_pre_i;
    end
  end

  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ug_i && !center_i && !dir_i && cnt_q >= arr_act_q) |=> (cnt_q == '0)); // R2
  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ug_i && !center_i && dir_i && cnt_q == '0) |=> (cnt_q == $past(arr_pre_i))); // R3
  AST_CENTER_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ug_i && center_i && !dirc_q && arr_act_q != '0 && cnt_q >= arr_act_q) |=> dirc_q); // R4
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          evt_i,
  input  logic          hw_upd_i,
  input  logic          dir_c_i,
  input  logic [CW-1:0] cnt_i,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] psc_pre_o,
  output logic [CW-1:0] arr_pre_o,
  output logic          arr_direct_o,
  output logic          ug_o,
  output logic          uie_o,
  output logic          uif_o,
  output logic [CW-1:0] rdata_o
);
  ctrl_t         ctrl_q, ctrl_rd;
  logic [CW-1:0] psc_q, arr_q;
  logic          uie_q, uif_q;
  logic          wr_ctrl, wr_stat;

  assign wr_ctrl      = we_i && (addr_i == A_CTRL);
  assign wr_stat      = we_i && (addr_i == A_STAT);
  assign ug_o         = we_i && (addr_i == A_EVT) && wdata_i[0];
  assign arr_direct_o = we_i && (addr_i == A_ARR) && !ctrl_q.arpe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      arr_q  <= '0;
      uie_q  <= 1'b0;
      uif_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= wdata_i[0];
        ctrl_q.cms  <= wdata_i[3:2];
        ctrl_q.opm  <= wdata_i[4];
        ctrl_q.arpe <= wdata_i[5];
        if (wdata_i[3:2] == 2'b00) ctrl_q.dir <= wdata_i[1];
      end else if (hw_upd_i && ctrl_q.opm) begin
        ctrl_q.en <= 1'b0;
      end
      if (we_i && addr_i == A_PSC) psc_q <= wdata_i;
      if (we_i && addr_i == A_ARR) arr_q <= wdata_i;
      if (we_i && addr_i == A_IEN) uie_q <= wdata_i[0];
      if (evt_i)        uif_q <= 1'b1;
      else if (wr_stat) uif_q <= uif_q & wdata_i[0];
    end
  end

  always_comb begin
    ctrl_rd     = ctrl_q;
    ctrl_rd.dir = (ctrl_q.cms != 2'b00) ? dir_c_i : ctrl_q.dir;
    rdata_o     = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_rd;
      A_PSC:   rdata_o = psc_q;
      A_ARR:   rdata_o = arr_q;
      A_IEN:   rdata_o[0] = uie_q;
      A_STAT:  rdata_o[0] = uif_q;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign psc_pre_o = psc_q;
  assign arr_pre_o = arr_q;
  assign uie_o     = uie_q;
  assign uif_o     = uif_q;

  AST_OPM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_upd_i && ctrl_q.opm && !wr_ctrl) |=> !ctrl_q.en); // R5
  AST_UIF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uif_q) |-> $past(evt_i)); // R8
  AST_UIF_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && uif_q) |=> uif_q); // R8
endmodule

// File: rtl/tmr_base_unit.sv
module tmr_base_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [CW-1:0] bus_wdata_i,
  output logic [CW-1:0] bus_rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          dir_down_o,
  output logic          upd_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic [CW-1:0] psc_pre, arr_pre, cnt;
  logic          arr_direct, ug, uie, uif;
  logic          tick, evt, hw_upd, dir_c, center, upd_q;

  assign center = (ctrl.cms != 2'b00);

  tmr_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .evt_i(evt), .hw_upd_i(hw_upd), .dir_c_i(dir_c), .cnt_i(cnt),
    .ctrl_o(ctrl), .psc_pre_o(psc_pre), .arr_pre_o(arr_pre),
    .arr_direct_o(arr_direct), .ug_o(ug), .uie_o(uie), .uif_o(uif),
    .rdata_o(bus_rdata_o)
  );

  tmr_prescaler #(.CW(CW)) u_psc (
    .clk_i, .rst_ni,
    .en_i(ctrl.en), .upd_i(evt), .psc_pre_i(psc_pre), .tick_o(tick)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(tick), .ug_i(ug), .center_i(center), .dir_i(ctrl.dir),
    .arr_pre_i(arr_pre), .arr_direct_i(arr_direct), .arr_wdata_i(bus_wdata_i),
    .cnt_o(cnt), .dir_c_o(dir_c), .evt_o(evt), .hw_upd_o(hw_upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= evt;
  end

  assign cnt_o      = cnt;
  assign dir_down_o = center ? dir_c : ctrl.dir;
  assign upd_o      = upd_q;
  assign irq_o      = uif & uie;

  AST_UPD_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_upd && !center && !ctrl.dir) |=> (upd_o && cnt_o == '0)); // R10
endmodule

// File: tb/tmr_base_unit_bench.sv
module tmr_base_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 0, A_EVT = 1, A_PSC = 2, A_ARR = 3,
                         A_IEN = 4, A_STAT = 5, A_CNT = 6;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata, cnt;
  logic        dir_down, upd, irq;

  int n_chk = 0, n_err = 0;
  bit done = 0, chk_on = 0;

  tmr_base_unit u_tmr_base_unit (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cnt_o(cnt),
    .dir_down_o(dir_down), .upd_o(upd), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model, written from the requirements
  logic        m_en, m_dir, m_opm, m_arpe, m_dirc, m_uie, m_uif, m_upd;
  logic [1:0]  m_cms;
  logic [15:0] m_psc, m_psc_act, m_pcnt, m_arr, m_arr_act, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_dir = 0; m_opm = 0; m_arpe = 0; m_dirc = 0; m_uie = 0;
      m_uif = 0; m_upd = 0; m_cms = 0; m_psc = 0; m_psc_act = 0;
      m_pcnt = 0; m_arr = 0; m_arr_act = 0; m_cnt = 0;
    end else begin
      logic        center, tick, ug, evt, hw, n_en, n_dirc, n_uif;
      logic [15:0] n_cnt, n_pcnt, n_arr_act, n_psc_act;
      center = (m_cms != 0);
      tick = m_en && (m_pcnt == m_psc_act);
      ug = we && addr == A_EVT && wdata[0];
      evt = 0; hw = 0;
      n_cnt = m_cnt; n_pcnt = m_pcnt; n_dirc = m_dirc; n_en = m_en;
      n_arr_act = m_arr_act; n_psc_act = m_psc_act; n_uif = m_uif;
      if (ug) begin
        evt = 1; n_pcnt = 0; n_dirc = 0;
        n_cnt = (!center && m_dir) ? m_arr : 16'd0;
      end else if (tick) begin
        n_pcnt = 0;
        if (center) begin
          if (m_arr_act == 0) begin n_cnt = 0; hw = 1; end
          else if (!m_dirc) begin
            if (m_cnt >= m_arr_act) begin n_cnt = m_arr_act - 1; n_dirc = 1; hw = 1; end
            else n_cnt = m_cnt + 1;
          end else begin
            if (m_cnt == 0) begin n_cnt = 1; n_dirc = 0; hw = 1; end
            else n_cnt = m_cnt - 1;
          end
        end else if (m_dir) begin
          if (m_cnt == 0) begin n_cnt = m_arr; hw = 1; end else n_cnt = m_cnt - 1;
        end else begin
          if (m_cnt >= m_arr_act) begin n_cnt = 0; hw = 1; end else n_cnt = m_cnt + 1;
        end
        evt = hw;
      end else if (m_en) n_pcnt = m_pcnt + 1;
      if (evt) begin n_arr_act = m_arr; n_psc_act = m_psc; n_uif = 1; end
      if (we && addr == A_CTRL) begin
        n_en = wdata[0];
        if (wdata[3:2] == 0) m_dir = wdata[1];
        m_cms = wdata[3:2]; m_opm = wdata[4];
      end else if (hw && m_opm) n_en = 0;
      if (we && addr == A_ARR && !m_arpe) n_arr_act = wdata;
      if (we && addr == A_ARR) m_arr = wdata;
      if (we && addr == A_PSC) m_psc = wdata;
      if (we && addr == A_IEN) m_uie = wdata[0];
      if (we && addr == A_STAT && !evt) n_uif = m_uif & wdata[0];
      if (we && addr == A_CTRL) m_arpe = wdata[5];
      m_cnt = n_cnt; m_pcnt = n_pcnt; m_dirc = n_dirc; m_en = n_en;
      m_arr_act = n_arr_act; m_psc_act = n_psc_act; m_uif = n_uif; m_upd = evt;
    end
  end

  function automatic logic m_dirout();
    return (m_cms != 0) ? m_dirc : m_dir;
  endfunction

  function automatic logic [15:0] m_read(logic [2:0] a);
    case (a)
      A_CTRL: return {10'd0, m_arpe, m_opm, m_cms, m_dirout(), m_en};
      A_PSC:  return m_psc;
      A_ARR:  return m_arr;
      A_IEN:  return {15'd0, m_uie};
      A_STAT: return {15'd0, m_uif};
      A_CNT:  return m_cnt;
      default: return 16'd0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      string t;
      t = (m_cms != 0) ? "R4 count" : (m_dir ? "R3 count" : "R2 count");
      check(t, cnt, m_cnt);
      check("R4 dir_down", dir_down, m_dirout());
      check("R10 upd pulse", upd, m_upd);
      check("R9 irq", irq, m_uif & m_uie);
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; #1; v = rdata;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, int exp);
    logic [15:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic period(output int p);
    logic [15:0] c0;
    int n;
    @(negedge clk); c0 = cnt; n = 0;
    while (cnt == c0 && n < 200) begin @(negedge clk); n++; end
    c0 = cnt; p = 0;
    while (cnt == c0 && p < 200) begin @(negedge clk); p++; end
  endtask

  task automatic max_until_wrap(output int mx);
    int n;
    mx = cnt; n = 0;
    @(negedge clk);
    while (cnt != 0 && n < 200) begin
      if (cnt > mx) mx = cnt;
      @(negedge clk); n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p, mx;
    logic [15:0] v;
    void'($urandom(32'h5eed_7a11));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 cnt", cnt, 0);
    check("R11 irq", irq, 0);
    check("R11 upd", upd, 0);
    check("R11 dir", dir_down, 0);
    rd_chk("R11 ctrl", A_CTRL, 0);
    rd_chk("R11 stat", A_STAT, 0);
    rd_chk("R11 arr", A_ARR, 0);
    rd_chk("R11 cnt read", A_CNT, 0);
    chk_on = 1;

    // R1 divider period and buffering
    wr(A_PSC, 2); wr(A_ARR, 100); wr(A_EVT, 1); wr(A_CTRL, 16'h01);
    period(p); check("R1 period psc=2", p, 3);
    wr(A_PSC, 0);
    period(p); check("R1 psc buffered until update", p, 3);
    wr(A_EVT, 1);
    period(p); check("R1 psc after update", p, 1);

    // R6 buffered period
    wr(A_CTRL, 0); wr(A_ARR, 5); wr(A_EVT, 1); wr(A_CTRL, 16'h21);
    wr(A_ARR, 2);
    max_until_wrap(mx); check("R6 preload holds old period", mx, 5);
    max_until_wrap(mx); check("R6 preload applied at update", mx, 2);
    // R6 direct period
    wr(A_CTRL, 0); wr(A_ARR, 9); wr(A_EVT, 1); wr(A_CTRL, 16'h01);
    wr(A_ARR, 3);
    max_until_wrap(mx); check("R6 direct period write", mx, 3);

    // R5 single shot
    wr(A_CTRL, 0); wr(A_ARR, 4); wr(A_EVT, 1); wr(A_CTRL, 16'h11);
    repeat (12) @(negedge clk);
    rd(A_CTRL, v); check("R5 enable cleared", v[0], 0);
    check("R5 counter held", cnt, 0);
    repeat (3) @(negedge clk);
    check("R5 counter still held", cnt, 0);

    // R7 software update in down mode
    wr(A_CTRL, 16'h02); wr(A_ARR, 7); wr(A_STAT, 0); wr(A_EVT, 1);
    rd_chk("R7 counter loaded", A_CNT, 7);
    rd_chk("R7 flag set", A_STAT, 1);

    // R8 flag write semantics
    wr(A_STAT, 16'hFFFF); rd_chk("R8 write one keeps", A_STAT, 1);
    wr(A_STAT, 0);        rd_chk("R8 write zero clears", A_STAT, 0);

    // R9 interrupt mask
    wr(A_IEN, 0); wr(A_EVT, 1);
    @(negedge clk); check("R9 masked irq", irq, 0);
    wr(A_IEN, 1);
    @(negedge clk); check("R9 unmasked irq", irq, 1);
    wr(A_STAT, 0);
    @(negedge clk); check("R9 irq after clear", irq, 0);

    // R4 triangle: direction bit ignored, phase on read
    wr(A_CTRL, 16'h04); wr(A_EVT, 1); wr(A_CTRL, 16'h06);
    rd(A_CTRL, v); check("R4 dir write ignored", v[1], 0);
    wr(A_ARR, 3); wr(A_EVT, 1); wr(A_CTRL, 16'h05);
    p = 0;
    while (!dir_down && p < 50) begin @(negedge clk); p++; end
    check("R4 first falling value", cnt, 2);
    rd(A_CTRL, v); check("R4 phase read", v[1], 1);

    // random configurations
    for (int seg = 0; seg < 40; seg++) begin
      int r;
      logic [15:0] c;
      r = $urandom % 3;
      c = 16'h0001;
      if (r == 1) c[1] = 1;
      if (r == 2) c[3:2] = 2'(($urandom % 3) + 1);
      if ($urandom % 6 == 0) c[4] = 1;
      c[5] = 1'($urandom % 2);
      wr(A_CTRL, 0);
      wr(A_PSC, 16'($urandom % 4));
      wr(A_ARR, 16'($urandom % 13));
      wr(A_IEN, 16'($urandom % 2));
      wr(A_EVT, 1);
      wr(A_STAT, 0);
      wr(A_CTRL, c);
      for (int k = 0; k < 60; k++) begin
        r = $urandom % 12;
        case (r)
          0: wr(A_ARR, 16'($urandom % 13));
          1: wr(A_STAT, 16'($urandom % 2));
          2: wr(A_PSC, 16'($urandom % 4));
          3: begin
            logic [2:0] a;
            a = 3'($urandom % 7);
            rd(a, v);
            check("R11 register readback", v, m_read(a));
          end
          4: wr(A_EVT, 1);
          default: @(negedge clk);
        endcase
      end
    end
    finish_run();
  end
endmodule